// File: doc/BRIEF.md
# Paired register load/store sequencer

This block takes one custom-opcode instruction that names two general-purpose registers, a base register and a small scaled offset, and turns it into two back-to-back memory accesses. A load form reads two consecutive words or doublewords and hands both results to two register-file write ports together. A store form writes the values of the two named registers to two consecutive locations. A mode input selects a 32-bit or a 64-bit register width. In 32-bit mode the addresses wrap at 32 bits, and the doubleword forms are refused.

The instruction enters on a valid/ready handshake. `ins_ready` is high only while the block is idle, so a caller holding `ins_valid` with a new word simply waits; nothing is queued. The block presents the base register index decoded from the incoming word on `ins_base_idx`, so the caller can look up the operand values in the same cycle. The memory side is a request/acknowledge port. A request and all of its fields stay unchanged until the cycle in which `mem_ack` is seen. A word that is not a supported form, or is not allowed in the current mode, is consumed and reported on `illegal` with no memory traffic.

Top module: `pairmem_seq`

## Requirements
- R1: An instruction is a supported form only when bits 6:0 are 0001011 and bits 14:12 are 100 (load pair) or 101 (store pair). Bits 31:27 choose the form: 11111 is doubleword load or store, 11100 is word load with sign extension or word store, and 11110 is word load with zero extension. The register fields are rd1 in bits 11:7, base in bits 19:15, rd2 in bits 24:20 and the 2-bit scale in bits 26:25.
- R2: The first access address is base plus scale shifted left by 4 for doubleword forms, or by 3 for word forms, wrapping modulo 2^64.
- R3: The second access address is the first plus 8 for doubleword forms, or plus 4 for word forms. `mem_size` is 1 for a doubleword access and 0 for a word access.
- R4: When `narrow_mode` is 1, both addresses are reduced to their low 32 bits, with the upper 32 bits driven to zero.
- R5: The first request is held, with its address, size, write enable and data unchanged, until it is acknowledged. Only then is the second request issued. Store forms drive `mem_we`=1 with the rd1 value at the first address and the rd2 value at the second.
- R6: For a load form, both write ports pulse for exactly one cycle, in the cycle of the second acknowledge and never earlier. Port 1 carries the first result with index rd1, and port 2 carries the second result with index rd2.
- R7: A doubleword load returns the full 64 bits. A word load takes bits 31:0 of the read data and sign-extends them (11100) or zero-extends them (11110) to 64 bits. In `narrow_mode`, the upper 32 bits of word results are zero.
- R8: A write port whose register index is 0 does not pulse.
- R9: Any word that is not a supported form, and any doubleword form while `narrow_mode` is 1, is consumed. `illegal` then pulses for one cycle, in the cycle after acceptance, with no memory request, and the block stays idle.
- R10: `ins_ready` is high exactly when the block is idle. `busy` is high from the cycle after a legal word is accepted through the cycle of the second acknowledge. A word offered while busy is not accepted and causes no extra access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block is idle and takes the word |
| ins_word | input | 32 | Instruction word |
| ins_base_idx | output | 5 | Base register index decoded from `ins_word` |
| base_val | input | XLEN | Value of the base register |
| src1_val | input | XLEN | Value of the rd1 register (store data, first) |
| src2_val | input | XLEN | Value of the rd2 register (store data, second) |
| narrow_mode | input | 1 | 1 selects 32-bit register width |
| busy | output | 1 | Access pair in progress |
| illegal | output | 1 | One-cycle pulse for a refused word |
| mem_req | output | 1 | Memory request |
| mem_ack | input | 1 | Memory acknowledge |
| mem_addr | output | XLEN | Access address |
| mem_size | output | 1 | 1 doubleword, 0 word |
| mem_we | output | 1 | 1 for a write access |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with `mem_ack` |
| wb1_en | output | 1 | Write port 1 strobe |
| wb1_idx | output | 5 | Write port 1 register index |
| wb1_data | output | XLEN | Write port 1 data |
| wb2_en | output | 1 | Write port 2 strobe |
| wb2_idx | output | 5 | Write port 2 register index |
| wb2_data | output | XLEN | Write port 2 data |

## Verification
The assertions check the cycle-level rules on every cycle: a pending request holding steady, write strobes occurring only alongside a read acknowledge, no strobe for register 0, a refused word leaving the memory port quiet, and busy rising only after an offered word. The bench scenarios cover what a property cannot see. These are the decoded form table, the address arithmetic including 64-bit wrap and 32-bit truncation, the sign and zero extension of word results, the store data order, and the refusal of a word offered while the block is busy.

// File: rtl/pairmem_pkg.sv
package pairmem_pkg;
  localparam logic [6:0] PM_OPCODE   = 7'b0001011;
  localparam logic [2:0] PM_F3_LOAD  = 3'b100;
  localparam logic [2:0] PM_F3_STORE = 3'b101;
  localparam logic [4:0] PM_SEL_DW   = 5'b11111;
  localparam logic [4:0] PM_SEL_WS   = 5'b11100;
  localparam logic [4:0] PM_SEL_WU   = 5'b11110;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} pm_state_e;
  typedef enum logic [1:0] {SZ_DWORD, SZ_WORD_S, SZ_WORD_U} pm_kind_e;

  typedef struct packed {
    logic       legal;
    logic       is_store;
    pm_kind_e   kind;
    logic [1:0] scale;
    logic [4:0] reg_a;
    logic [4:0] reg_b;
    logic [4:0] reg_base;
  } pm_dec_t;
endpackage

// File: rtl/pairmem_decode.sv
module pairmem_decode
  import pairmem_pkg::*;
(
  input  logic [31:0] word,
  input  logic        narrow,
  output pm_dec_t     dec
);
  logic [4:0] sel;
  logic [2:0] f3;
  logic       op_ok, is_ld, is_st;

  assign sel   = word[31:27];
  assign f3    = word[14:12];
  assign op_ok = (word[6:0] == PM_OPCODE);
  assign is_ld = (f3 == PM_F3_LOAD);
  assign is_st = (f3 == PM_F3_STORE);

  always_comb begin
    dec.scale    = word[26:25];
    dec.reg_b    = word[24:20];
    dec.reg_base = word[19:15];
    dec.reg_a    = word[11:7];
    dec.is_store = is_st;
    dec.kind     = SZ_DWORD;
    dec.legal    = 1'b0;
    if (op_ok && (is_ld || is_st)) begin
      case (sel)
        PM_SEL_DW: begin dec.kind = SZ_DWORD;  dec.legal = !narrow; end
        PM_SEL_WS: begin dec.kind = SZ_WORD_S; dec.legal = 1'b1;    end
        PM_SEL_WU: begin dec.kind = SZ_WORD_U; dec.legal = is_ld;   end
        default:   dec.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pairmem_agen.sv
module pairmem_agen #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [1:0]      scale,
  input  logic            dword,
  input  logic            narrow,
  output logic [XLEN-1:0] addr_a,
  output logic [XLEN-1:0] addr_b
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] off, step, sum_a, sum_b, keep;

  always_comb begin
    off    = {{(XLEN-2){1'b0}}, scale} << (dword ? 3'd4 : 3'd3);
    step   = dword ? XLEN'(8) : XLEN'(4);
    sum_a  = base + off;
    sum_b  = sum_a + step;
    keep   = narrow ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
    addr_a = sum_a & keep;
    addr_b = sum_b & keep;
  end
endmodule

// File: rtl/pairmem_ext.sv
module pairmem_ext
  import pairmem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  pm_kind_e        kind,
  input  logic            narrow,
  output logic [XLEN-1:0] val
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (kind == SZ_DWORD)
      val = raw;
    else if (kind == SZ_WORD_S && !narrow)
      val = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    else
      val = {{HALF{1'b0}}, raw[HALF-1:0]};
  end
endmodule

// File: rtl/pairmem_seq.sv
module pairmem_seq
  import pairmem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [31:0]     ins_word,
  output logic [4:0]      ins_base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] src1_val,
  input  logic [XLEN-1:0] src2_val,
  input  logic            narrow_mode,
  output logic            busy,
  output logic            illegal,
  output logic            mem_req,
  input  logic            mem_ack,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_size,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wb1_en,
  output logic [4:0]      wb1_idx,
  output logic [XLEN-1:0] wb1_data,
  output logic            wb2_en,
  output logic [4:0]      wb2_idx,
  output logic [XLEN-1:0] wb2_data
);
  localparam int SLOTS = 2;

  pm_dec_t         dec;
  pm_state_e       st;
  logic            is_store_q, narrow_q, illegal_q;
  pm_kind_e        kind_q;
  logic [4:0]      idx_a_q, idx_b_q;
  logic [XLEN-1:0] addr_a_q, addr_b_q, dat_a_q, dat_b_q, first_q;
  logic [XLEN-1:0] addr_a_d, addr_b_d;
  logic [XLEN-1:0] raw_arr [SLOTS];
  logic [XLEN-1:0] ext_arr [SLOTS];
  logic            accept, finish;

  pairmem_decode u_dec (.word(ins_word), .narrow(narrow_mode), .dec(dec));

  pairmem_agen #(.XLEN(XLEN)) u_agen (
    .base(base_val), .scale(dec.scale), .dword(dec.kind == SZ_DWORD),
    .narrow(narrow_mode), .addr_a(addr_a_d), .addr_b(addr_b_d)
  );

  assign raw_arr[0] = first_q;
  assign raw_arr[1] = mem_rdata;

  for (genvar g = 0; g < SLOTS; g++) begin : g_ext
    pairmem_ext #(.XLEN(XLEN)) u_ext (
      .raw(raw_arr[g]), .kind(kind_q), .narrow(narrow_q), .val(ext_arr[g])
    );
  end

  assign ins_ready    = (st == ST_IDLE);
  assign ins_base_idx = dec.reg_base;
  assign accept       = ins_valid && ins_ready;
  assign busy         = (st != ST_IDLE);
  assign illegal      = illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      is_store_q <= 1'b0;
      narrow_q   <= 1'b0;
      illegal_q  <= 1'b0;
      kind_q     <= SZ_DWORD;
      idx_a_q    <= '0;
      idx_b_q    <= '0;
      addr_a_q   <= '0;
      addr_b_q   <= '0;
      dat_a_q    <= '0;
      dat_b_q    <= '0;
      first_q    <= '0;
    end else begin
      illegal_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (dec.legal) begin
              st         <= ST_FIRST;
              is_store_q <= dec.is_store;
              kind_q     <= dec.kind;
              narrow_q   <= narrow_mode;
              idx_a_q    <= dec.reg_a;
              idx_b_q    <= dec.reg_b;
              addr_a_q   <= addr_a_d;
              addr_b_q   <= addr_b_d;
              dat_a_q    <= src1_val;
              dat_b_q    <= src2_val;
            end else begin
              illegal_q <= 1'b1;
            end
          end
        end
        ST_FIRST: begin
          if (mem_ack) begin
            first_q <= mem_rdata;
            st      <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (mem_ack) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = busy;
  assign mem_we    = is_store_q;
  assign mem_size  = (kind_q == SZ_DWORD);
  assign mem_addr  = (st == ST_SECOND) ? addr_b_q : addr_a_q;
  assign mem_wdata = (st == ST_SECOND) ? dat_b_q : dat_a_q;

  assign finish   = (st == ST_SECOND) && mem_ack && !is_store_q;
  assign wb1_en   = finish && (idx_a_q != 5'd0);
  assign wb2_en   = finish && (idx_b_q != 5'd0);
  assign wb1_idx  = idx_a_q;
  assign wb2_idx  = idx_b_q;
  assign wb1_data = ext_arr[0];
  assign wb2_data = ext_arr[1];

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata) && $stable(mem_size));
  // R6
  wb_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb1_en || wb2_en) |-> mem_req && mem_ack && !mem_we);
  // R8
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb1_en |-> wb1_idx != 5'd0) and (wb2_en |-> wb2_idx != 5'd0));
  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req && ins_ready);
  // R10
  busy_after_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ins_valid));
endmodule

// File: tb/sim_pairmem_seq.sv
`timescale 1ns/1ps
module sim_pairmem_seq;
  localparam logic [6:0] OPC = 7'b0001011;

  typedef struct packed {
    logic [31:0] word;
    logic [63:0] base;
    logic        narrow;
    logic [1:0]  dly;
  } vec_t;

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [1:0] sh,
                                     input logic [4:0] r2, input logic [4:0] rs,
                                     input logic [2:0] f3, input logic [4:0] r1,
                                     input logic [6:0] opc);
    return {op, sh, r2, rs, f3, r1, opc};
  endfunction

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{mk(5'b11111, 2'd1, 5'd6,  5'd2, 3'b100, 5'd5,  OPC), 64'h1000, 1'b0, 2'd0},
    '{mk(5'b11100, 2'd3, 5'd8,  5'd2, 3'b100, 5'd7,  OPC), 64'h2000, 1'b0, 2'd1},
    '{mk(5'b11110, 2'd2, 5'd10, 5'd2, 3'b100, 5'd9,  OPC), 64'h3000, 1'b0, 2'd2},
    '{mk(5'b11111, 2'd0, 5'd12, 5'd2, 3'b101, 5'd11, OPC), 64'h4000, 1'b0, 2'd0},
    '{mk(5'b11100, 2'd1, 5'd14, 5'd2, 3'b101, 5'd13, OPC), 64'hFFFF_FFF8, 1'b1, 2'd1},
    '{mk(5'b11100, 2'd1, 5'd16, 5'd2, 3'b100, 5'd15, OPC), 64'h7FFF_FFF8, 1'b1, 2'd0},
    '{mk(5'b11111, 2'd0, 5'd5,  5'd2, 3'b100, 5'd4,  OPC), 64'h5000, 1'b1, 2'd0},
    '{mk(5'b10101, 2'd0, 5'd5,  5'd2, 3'b100, 5'd4,  OPC), 64'h5000, 1'b0, 2'd0},
    '{mk(5'b11100, 2'd0, 5'd3,  5'd2, 3'b100, 5'd0,  OPC), 64'h6000, 1'b0, 2'd1},
    '{mk(5'b11111, 2'd1, 5'd0,  5'd2, 3'b100, 5'd17, OPC), 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 2'd0},
    '{mk(5'b11111, 2'd2, 5'd5,  5'd2, 3'b101, 5'd4,  OPC), 64'h7000, 1'b1, 2'd0},
    '{mk(5'b11100, 2'd0, 5'd5,  5'd2, 3'b100, 5'd4,  7'b0001111), 64'h5000, 1'b0, 2'd0},
    '{mk(5'b11110, 2'd3, 5'd20, 5'd2, 3'b101, 5'd21, OPC), 64'h5000, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic [4:0]  ins_base_idx;
  logic [63:0] base_val = '0, src1_val = '0, src2_val = '0;
  logic        narrow_mode = 1'b0;
  logic        busy, illegal, mem_req, mem_size, mem_we;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        wb1_en, wb2_en;
  logic [4:0]  wb1_idx, wb2_idx;
  logic [63:0] wb1_data, wb2_data;

  always #4 clk = ~clk;

  pairmem_seq #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_base_idx(ins_base_idx), .base_val(base_val),
    .src1_val(src1_val), .src2_val(src2_val), .narrow_mode(narrow_mode),
    .busy(busy), .illegal(illegal), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb1_en(wb1_en),
    .wb1_idx(wb1_idx), .wb1_data(wb1_data), .wb2_en(wb2_en),
    .wb2_idx(wb2_idx), .wb2_data(wb2_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int mem_dly = 0;
  int log_n = 0;
  logic [63:0] log_addr [4];
  logic [63:0] log_wdata [4];
  logic        log_we [4];
  logic        log_size [4];
  int wb1_cnt = 0, wb2_cnt = 0, ill_cnt = 0, early_wb = 0;
  logic [63:0] wb1_got, wb2_got;
  logic [4:0]  wb1_i, wb2_i;

  function automatic logic [63:0] memval(input logic [63:0] a);
    return {~a[31:0], a[31:0] ^ 32'h8000_1234};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0; cnt = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (cnt >= mem_dly) begin
          mem_ack   = 1'b1;
          mem_rdata = memval(mem_addr);
          if (log_n < 4) begin
            log_addr[log_n]  = mem_addr;
            log_wdata[log_n] = mem_wdata;
            log_we[log_n]    = mem_we;
            log_size[log_n]  = mem_size;
          end
          log_n++;
        end else cnt++;
      end
    end
  end

  // output monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (wb1_en) begin wb1_cnt++; wb1_got = wb1_data; wb1_i = wb1_idx; end
      if (wb2_en) begin wb2_cnt++; wb2_got = wb2_data; wb2_i = wb2_idx; end
      if ((wb1_en || wb2_en) && log_n != 2) early_wb++;
      if (illegal) ill_cnt++;
    end
  end

  task automatic clear_obs();
    log_n = 0; wb1_cnt = 0; wb2_cnt = 0; ill_cnt = 0; early_wb = 0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] b, input logic [63:0] s1,
                       input logic [63:0] s2, input logic nm);
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_word = w; base_val = b; src1_val = s1; src2_val = s2; narrow_mode = nm;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 60; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    logic [4:0] sel, r1, r2;
    logic [63:0] s1, s2, a1, a2, off, e1, e2, m1, m2;
    logic ld, st, legal, dw, sgn;
    v = VT[i];
    s1 = 64'h1111_2222_3333_0000 + 64'(i);
    s2 = 64'hAAAA_BBBB_CCCC_0000 + 64'(i);
    sel = v.word[31:27]; r1 = v.word[11:7]; r2 = v.word[24:20];
    ld = (v.word[14:12] == 3'b100); st = (v.word[14:12] == 3'b101);
    dw = (sel == 5'b11111); sgn = (sel == 5'b11100);
    legal = (v.word[6:0] == OPC) && (ld || st) &&
            ((dw && !v.narrow) || sgn || (sel == 5'b11110 && ld));
    off = 64'(v.word[26:25]) << (dw ? 4 : 3);
    a1 = v.base + off;
    a2 = a1 + (dw ? 64'd8 : 64'd4);
    if (v.narrow) begin a1 = {32'd0, a1[31:0]}; a2 = {32'd0, a2[31:0]}; end
    mem_dly = int'(v.dly);
    clear_obs();
    issue(v.word, v.base, s1, s2, v.narrow);
    drain();
    $display("vector %0d word=%h", i, v.word);
    chk("R9 illegal pulse count", 64'(ill_cnt), legal ? 64'd0 : 64'd1);
    chk("R5/R9 access count", 64'(log_n), legal ? 64'd2 : 64'd0);
    if (legal) begin
      chk("R2/R4 first address", log_addr[0], a1);
      chk("R3/R4 second address", log_addr[1], a2);
      chk("R3 size", {63'd0, log_size[0] & log_size[1]}, {63'd0, dw});
      chk("R5 write enable", {62'd0, log_we[0], log_we[1]}, st ? 64'd3 : 64'd0);
      if (st) begin
        chk("R5 store data first", log_wdata[0], s1);
        chk("R5 store data second", log_wdata[1], s2);
        chk("R6 no writeback for store", 64'(wb1_cnt + wb2_cnt), 64'd0);
      end else begin
        m1 = memval(a1); m2 = memval(a2);
        if (dw) begin e1 = m1; e2 = m2; end
        else if (sgn && !v.narrow) begin
          e1 = {{32{m1[31]}}, m1[31:0]}; e2 = {{32{m2[31]}}, m2[31:0]};
        end else begin
          e1 = {32'd0, m1[31:0]}; e2 = {32'd0, m2[31:0]};
        end
        chk("R8 port1 strobe count", 64'(wb1_cnt), (r1 != 0) ? 64'd1 : 64'd0);
        chk("R8 port2 strobe count", 64'(wb2_cnt), (r2 != 0) ? 64'd1 : 64'd0);
        chk("R6 no early writeback", 64'(early_wb), 64'd0);
        if (r1 != 0) begin
          chk("R7 port1 data", wb1_got, e1);
          chk("R6 port1 index", 64'(wb1_i), 64'(r1));
        end
        if (r2 != 0) begin
          chk("R7 port2 data", wb2_got, e2);
          chk("R6 port2 index", 64'(wb2_i), 64'(r2));
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready after reset", {63'd0, ins_ready}, 64'd1);
    chk("R10 busy after reset", {63'd0, busy}, 64'd0);
    chk("R5 no request after reset", {63'd0, mem_req}, 64'd0);
    chk("R6 no strobes after reset", {62'd0, wb1_en, wb2_en}, 64'd0);
    chk("R9 illegal low after reset", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 base index field", 64'(ins_base_idx), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1 base index decode is combinational from the offered word
    ins_word = mk(5'b11100, 2'd0, 5'd1, 5'd19, 3'b100, 5'd2, OPC);
    #1;
    chk("R1 base index field", 64'(ins_base_idx), 64'd19);

    // R10 busy window and a word offered while busy
    mem_dly = 3;
    clear_obs();
    issue(mk(5'b11100, 2'd0, 5'd6, 5'd2, 3'b100, 5'd5, OPC), 64'h9000, 64'd0, 64'd0, 1'b0);
    chk("R10 busy after acceptance", {63'd0, busy}, 64'd1);
    chk("R10 not ready while busy", {63'd0, ins_ready}, 64'd0);
    ins_word = mk(5'b11111, 2'd0, 5'd6, 5'd2, 3'b101, 5'd5, OPC);
    ins_valid = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    ins_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 offered word while busy ignored", 64'(log_n), 64'd2);
    chk("R10 idle afterwards", {63'd0, busy}, 64'd0);

    // R5 first request held while unacknowledged
    mem_dly = 3;
    clear_obs();
    issue(mk(5'b11111, 2'd3, 5'd6, 5'd2, 3'b101, 5'd5, OPC), 64'hA000, 64'd1, 64'd2, 1'b0);
    @(negedge clk);
    chk("R5 first request held address", mem_addr, 64'hA030);
    chk("R5 second not issued early", 64'(log_n), 64'd0);
    drain();
    chk("R5 accesses after hold", 64'(log_n), 64'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule